// File: doc/BRIEF.md
# Pipelined Byte-Lane Write Memory Core

This block is a synchronous single-port memory. The clock's rising edge registers the address, write data, write controls and chip selects. The registered command then acts on the storage array in the next cycle. A read puts the stored word on a registered output together with a valid flag, so read data has a pipelined latency of one cycle after the registration edge. A read can be issued on every clock.

Each word is 36 bits wide and is split into four 9-bit lanes. A write can update any subset of the lanes. A lane is written only when the byte-write enable and that lane's own write strobe are both high. The global write strobe overrides both and updates all four lanes at once.

Three chip-select inputs must all be in their active state before any operation takes place. This allows depth expansion with external decode. A deselected cycle turns the read output off after a single cycle.

Top module: `sram_bw_core`

## Requirements
- R1: Inputs take effect only at a rising clock edge. A read presented before edge k leaves `rvalid_o` low after edge k when the previous cycle was idle.
- R2: A read registered at edge k drives `rvalid_o` high and the stored word on `rdata_o` after edge k+1.
- R3: Lane i occupies bits [9i+8:9i]. With `gw_i` low and `bwe_i` high, lane i is written exactly when `lane_wr_i[i]` is 1, and the other lanes keep their contents.
- R4: With `gw_i` and `bwe_i` both low, `lane_wr_i` has no effect. The cycle is a read: it returns the stored word with `rvalid_o` high and changes no lane.
- R5: With `gw_i` high, all four lanes are written, whatever the values of `bwe_i` and `lane_wr_i`.
- R6: The device is selected only when `ce_a_i`=1, `ce_b_i`=1 and `ce_c_n_i`=0. Any other combination neither writes the array nor produces read data.
- R7: After a registered deselect or write cycle, the next output cycle has `rvalid_o` low and `rdata_o` equal to zero. Whenever `rvalid_o` is low, `rdata_o` is zero.
- R8: A read of an address in the cycle right after a write to it returns the newly written lanes merged with the lanes that were not written.
- R9: While in reset and directly after it, `rvalid_o` is low and `rdata_o` is zero.
- R10: Reads issued on consecutive cycles each return their own word on consecutive output cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, lane i at bits [9i+8:9i] |
| ce_a_i | input | 1 | Chip select, active high |
| ce_b_i | input | 1 | Chip select, active high |
| ce_c_n_i | input | 1 | Chip select, active low |
| gw_i | input | 1 | Global write of all lanes |
| bwe_i | input | 1 | Byte-write enable qualifying the lane strobes |
| lane_wr_i | input | LANES | Per-lane write strobes |
| rdata_o | output | LANES*LANE_W | Registered read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench tries every lane-strobe pattern under byte writes. If the byte-write enable were ignored, or a lane index were crossed, the merged word read back would differ from the arithmetic model. The bench also tries all eight chip-select combinations with a global write. A wrong polarity or a missing term would then either corrupt the target word or raise the valid flag. Write-then-read to the same address on adjacent cycles would expose a stale-read hazard. Read, deselect and read sequences would expose an output that lingers for a second cycle or shows up a cycle early.

// File: rtl/sram_bw_pkg.sv
package sram_bw_pkg;

    // Command held in the registered input stage
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/sram_bw_in_stage.sv
module sram_bw_in_stage
    import sram_bw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    ce_a_i,
    input  logic                    ce_b_i,
    input  logic                    ce_c_n_i,
    input  logic                    gw_i,
    input  logic                    bwe_i,
    input  logic [LANES-1:0]        lane_wr_i,
    output op_e                     op_o,
    output logic [ADDR_W-1:0]       addr_o,
    output logic [LANES*LANE_W-1:0] wdata_o,
    output logic [LANES-1:0]        mask_o
);

    localparam int DW = LANES * LANE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wdata;
        logic [LANES-1:0]  mask;
    } stage_t;

    stage_t s_d, s_q;
    logic   sel;

    always_comb begin
        sel     = ce_a_i & ce_b_i & ~ce_c_n_i;
        s_d     = s_q;
        s_d.addr  = addr_i;
        s_d.wdata = wdata_i;
        // Global write overrides the qualified lane strobes
        if (gw_i) begin
            s_d.mask = '1;
        end else if (bwe_i) begin
            s_d.mask = lane_wr_i;
        end else begin
            s_d.mask = '0;
        end
        if (!sel) begin
            s_d.op   = OP_IDLE;
            s_d.mask = '0;
        end else if (|s_d.mask) begin
            s_d.op = OP_WRITE;
        end else begin
            s_d.op = OP_READ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{op: OP_IDLE, addr: '0, wdata: '0, mask: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign op_o    = s_q.op;
    assign addr_o  = s_q.addr;
    assign wdata_o = s_q.wdata;
    assign mask_o  = s_q.mask;

endmodule

// File: rtl/sram_bw_array.sv
module sram_bw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << ADDR_W;

    // One storage column per lane so each lane has its own write enable
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] col_q [DEPTH];
        logic              lane_we;

        assign lane_we = we_i & mask_i[g];

        always_ff @(posedge clk) begin
            if (lane_we) begin
                col_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rdata_o[g*LANE_W +: LANE_W] = col_q[addr_i];
    end

endmodule

// File: rtl/sram_bw_out_stage.sv
module sram_bw_out_stage #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.valid = rd_en_i;
        o_d.data  = rd_en_i ? rdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign rdata_o  = o_q.data;
    assign rvalid_o = o_q.valid;

endmodule

// File: rtl/sram_bw_core.sv
module sram_bw_core
    import sram_bw_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    ce_a_i,
    input  logic                    ce_b_i,
    input  logic                    ce_c_n_i,
    input  logic                    gw_i,
    input  logic                    bwe_i,
    input  logic [LANES-1:0]        lane_wr_i,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rvalid_o
);

    localparam int DW = LANES * LANE_W;

    op_e               st_op;
    logic [ADDR_W-1:0] st_addr;
    logic [DW-1:0]     st_wdata;
    logic [LANES-1:0]  st_mask;
    logic [DW-1:0]     arr_rdata;

    sram_bw_in_stage #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .ce_a_i    (ce_a_i),
        .ce_b_i    (ce_b_i),
        .ce_c_n_i  (ce_c_n_i),
        .gw_i      (gw_i),
        .bwe_i     (bwe_i),
        .lane_wr_i (lane_wr_i),
        .op_o      (st_op),
        .addr_o    (st_addr),
        .wdata_o   (st_wdata),
        .mask_o    (st_mask)
    );

    sram_bw_array #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_array (
        .clk     (clk),
        .we_i    (st_op == OP_WRITE),
        .mask_i  (st_mask),
        .addr_i  (st_addr),
        .wdata_i (st_wdata),
        .rdata_o (arr_rdata)
    );

    sram_bw_out_stage #(
        .DW (DW)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (st_op == OP_READ),
        .rdata_i  (arr_rdata),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

endmodule

// File: rtl/sram_bw_core_chk.sv
module sram_bw_core_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr_i,
    input logic [LANES*LANE_W-1:0] wdata_i,
    input logic                    ce_a_i,
    input logic                    ce_b_i,
    input logic                    ce_c_n_i,
    input logic                    gw_i,
    input logic                    bwe_i,
    input logic [LANES-1:0]        lane_wr_i,
    input logic [LANES*LANE_W-1:0] rdata_o,
    input logic                    rvalid_o
);

    localparam int DW = LANES * LANE_W;

    logic sel_w, wr_w, rd_w;
    assign sel_w = ce_a_i & ce_b_i & ~ce_c_n_i;
    assign wr_w  = sel_w & (gw_i | (bwe_i & |lane_wr_i));
    assign rd_w  = sel_w & ~wr_w;

    // Previous-cycle global write, tracked to check read-after-write data
    logic              gw_prev_q;
    logic [ADDR_W-1:0] gw_addr_q;
    logic [DW-1:0]     gw_data_q;
    logic              raw_hit;
    assign raw_hit = rd_w & gw_prev_q & (addr_i == gw_addr_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gw_prev_q <= 1'b0;
            gw_addr_q <= '0;
            gw_data_q <= '0;
        end else begin
            gw_prev_q <= sel_w & gw_i;
            gw_addr_q <= addr_i;
            gw_data_q <= wdata_i;
        end
    end

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rd_w, 2)) |-> rvalid_o); // R2

    AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sel_w, 2) |-> (!rvalid_o && rdata_o == '0)); // R6

    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_w, 2) |-> !rvalid_o); // R7

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> rdata_o == '0); // R7

    AST_GW_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(raw_hit, 2)) |-> rdata_o == $past(gw_data_q, 2)); // R8

endmodule

bind sram_bw_core sram_bw_core_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ce_a_i    (ce_a_i),
    .ce_b_i    (ce_b_i),
    .ce_c_n_i  (ce_c_n_i),
    .gw_i      (gw_i),
    .bwe_i     (bwe_i),
    .lane_wr_i (lane_wr_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
);

// File: tb/sram_bw_core_bench.sv
module sram_bw_core_bench;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam logic [2:0] SEL = 3'b110; // {ce_a, ce_b, ce_c_n}

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [35:0]       wdata_i = '0;
    logic              ce_a_i = 1'b0;
    logic              ce_b_i = 1'b0;
    logic              ce_c_n_i = 1'b1;
    logic              gw_i = 1'b0;
    logic              bwe_i = 1'b0;
    logic [3:0]        lane_wr_i = '0;
    logic [35:0]       rdata_o;
    logic              rvalid_o;

    int checks = 0;
    int failures = 0;

    logic [35:0] model [DEPTH];

    logic        p1_v = 1'b0, p2_v = 1'b0;
    logic [35:0] p1_d = '0, p2_d = '0;
    string       p1_t = "R9", p2_t = "R9";

    always #5 clk = ~clk;

    sram_bw_core #(.ADDR_W(ADDR_W)) u_sram_bw_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .ce_a_i    (ce_a_i),
        .ce_b_i    (ce_b_i),
        .ce_c_n_i  (ce_c_n_i),
        .gw_i      (gw_i),
        .bwe_i     (bwe_i),
        .lane_wr_i (lane_wr_i),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    function automatic logic [35:0] pat(input int a, input int salt);
        logic [8:0] x;
        x = 9'(a * 5 + salt);
        return {9'(x ^ 9'h1A5), 9'(x + 9'd77), 9'(~x), 9'(x * 3 + 1)};
    endfunction

    task automatic check(input logic v, input logic [35:0] d,
                         input logic ev, input logic [35:0] ed, input string tag);
        checks++;
        if (v !== ev || d !== ed) begin
            failures++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, v, d, ev, ed);
        end
    endtask

    // One bench cycle: check the op issued two steps ago, then drive a new op
    task automatic step(input logic [2:0] ce, input int a, input logic [35:0] wd,
                        input logic gw, input logic bwe, input logic [3:0] ln,
                        input string tag);
        logic        sel, wr;
        logic [3:0]  m;
        @(negedge clk);
        check(rvalid_o, rdata_o, p2_v, p2_d, p2_t);
        p2_v = p1_v; p2_d = p1_d; p2_t = p1_t;
        sel = ce[2] & ce[1] & ~ce[0];
        m   = gw ? 4'hF : (bwe ? ln : 4'h0);
        wr  = sel & (|m);
        p1_v = sel & ~wr;
        p1_d = (sel & ~wr) ? model[a] : 36'h0;
        p1_t = tag;
        if (wr) begin
            for (int l = 0; l < 4; l++) begin
                if (m[l]) model[a][l*9 +: 9] = wd[l*9 +: 9];
            end
        end
        {ce_a_i, ce_b_i, ce_c_n_i} = ce;
        addr_i    = ADDR_W'(a);
        wdata_i   = wd;
        gw_i      = gw;
        bwe_i     = bwe;
        lane_wr_i = ln;
    endtask

    task automatic idle(input string tag);
        step(3'b001, 0, 36'h0, 1'b0, 1'b0, 4'h0, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 36'h0;
        repeat (3) @(negedge clk);
        check(rvalid_o, rdata_o, 1'b0, 36'h0, "R9 in reset");
        rst_n = 1'b1;
        idle("R9");
        idle("R9");

        // Fill every word with a global write, lane strobes left low
        for (int a = 0; a < DEPTH; a++) step(SEL, a, pat(a, 0), 1'b1, 1'b0, 4'h0, "R5 R7");
        // Back-to-back read sweep
        for (int a = 0; a < DEPTH; a++) step(SEL, a, 36'h0, 1'b0, 1'b0, 4'h0, "R2 R10");
        idle("R1"); idle("R1");

        // Isolated read: output low the cycle before, valid exactly one cycle
        step(SEL, 5, 36'h0, 1'b0, 1'b0, 4'h0, "R2");
        idle("R1"); idle("R1"); idle("R1");

        // Every lane-strobe pattern under the byte-write enable, read right after
        for (int m = 0; m < 16; m++) begin
            step(SEL, 10 + m, pat(m, 99), 1'b0, 1'b1, 4'(m), "R3");
            step(SEL, 10 + m, 36'h0, 1'b0, 1'b0, 4'h0, "R8 R3");
        end

        // Lane strobes without the enable: a read, nothing written
        for (int m = 1; m < 16; m++) begin
            step(SEL, 30 + m, ~pat(m, 7), 1'b0, 1'b0, 4'(m), "R4");
            step(SEL, 30 + m, 36'h0, 1'b0, 1'b0, 4'h0, "R4");
        end

        // Global write overrides a partial byte write
        step(SEL, 60, 36'hA_5A5A_5A5A, 1'b1, 1'b1, 4'b0101, "R5");
        step(SEL, 60, 36'h0, 1'b0, 1'b0, 4'h0, "R5 R8");

        // All chip-select combinations: only 3'b110 may act
        for (int c = 0; c < 8; c++) begin
            step(3'(c), 50, 36'h3_1234_5678 + 36'(c), 1'b1, 1'b0, 4'h0, "R6");
            step(3'(c), 50, 36'h0, 1'b0, 1'b0, 4'h0, "R6");
            step(SEL, 50, 36'h0, 1'b0, 1'b0, 4'h0, "R6");
        end

        // Single-cycle turn-off between reads
        step(SEL, 20, 36'h0, 1'b0, 1'b0, 4'h0, "R10");
        idle("R7");
        step(SEL, 21, 36'h0, 1'b0, 1'b0, 4'h0, "R10");
        step(SEL, 22, pat(22, 3), 1'b0, 1'b1, 4'b1000, "R7");
        step(SEL, 22, 36'h0, 1'b0, 1'b0, 4'h0, "R8");

        idle("R7"); idle("R7"); idle("R7");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule